// File: doc/BRIEF.md
# Byte-Wide Channel Slave Cycle Controller

This block is the slave side of an 8-bit card on a Micro Channel style bus. It responds to I/O reads and writes in a small register window, and to memory reads and writes in a shared memory window. A local register file or buffer memory serves both windows through a request/acknowledge port. The local side can also write that buffer by its own path, so data reaches the host through the memory window.

A bus cycle begins on the falling edge of the address-latch strobe. At that point the block decodes the address, the memory/I-O status and the direction. On a hit it pulls its card-selected feedback low and drives channel-ready low to stretch the cycle. It holds the stretch until the local side answers, or until a programmable timeout runs out. For reads it then drives the fetched byte onto the data bus.

The end of a cycle is taken only from the command strobe. That strobe is synchronised and must be seen high on two consecutive samples. An address-extension qualifier that the host may drop between byte sub-cycles takes part only in memory decode, at latch time. It never ends a cycle. Hosts that split a wide access into four 8-bit sub-cycles are therefore served one byte at a time, with no early release of the data drivers.

Top module: `chan8_slave`

## Requirements
- R1: After synchronous reset, bus_rdy is 1, bus_sel_n is 1, bus_data_oe is 0 and loc_req is 0.
- R2: A cycle starts on the falling edge of bus_adl_n after synchronisation. An I/O access (bus_mio=0) hits when bus_addr[23:3] equals 24'h000300[23:3]. On a hit, bus_sel_n goes low and bus_rdy goes low. On a miss, bus_sel_n, bus_rdy and bus_data_oe keep their idle values and loc_req stays 0.
- R3: A memory access (bus_mio=1) hits only when bus_addr[23:8] equals 24'h0D4000[23:8] and bus_qual is 1 when the address is latched. With bus_qual at 0, the access is a miss.
- R4: On a read hit (bus_wr=0), bus_data_oe is 1 from the local request onward. bus_rdy stays 0 until loc_ack. After loc_ack, bus_rdy is 1 and bus_dout carries the loc_rdata byte.
- R5: bus_data_oe and bus_sel_n are released only after bus_cmd_n has been seen high on two consecutive synchronised samples. A high pulse lasting one clock leaves both asserted.
- R6: Changes on bus_qual after the address is latched have no effect on bus_sel_n, bus_data_oe or the end of the cycle.
- R7: On a write hit (bus_wr=1), bus_din is captured one clock after bus_cmd_n is first seen low. loc_we=1 and loc_wdata and loc_addr are held stable while loc_req is 1. bus_rdy returns to 1 after loc_ack, and bus_sel_n stays low until the end rule of R5.
- R8: If loc_ack does not arrive within cfg_timeout clocks of loc_req, loc_req drops, bus_rdy returns to 1 and a read returns 8'hFF. A cfg_timeout of 0 disables the timeout.
- R9: Four consecutive byte sub-cycles to adjacent window addresses, with bus_qual toggling during each, each return their own stored byte.
- R10: loc_space is 0 for I/O and 1 for memory. loc_addr is bus_addr[7:0] for memory and bus_addr[2:0] zero-extended for I/O.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_timeout | input | TO_W | Local acknowledge timeout in clocks, 0 = none |
| bus_adl_n | input | 1 | Address-latch strobe, active low |
| bus_cmd_n | input | 1 | Command strobe, active low |
| bus_mio | input | 1 | 1 = memory access, 0 = I/O access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_qual | input | 1 | Address-extension qualifier, used for memory decode at latch only |
| bus_addr | input | ADDR_W | Bus address |
| bus_din | input | 8 | Data bus as driven by the host |
| bus_dout | output | 8 | Read data toward the bus |
| bus_data_oe | output | 1 | Data bus output enable |
| bus_rdy | output | 1 | Channel ready, 0 = stretch |
| bus_sel_n | output | 1 | Card-selected feedback, active low |
| loc_req | output | 1 | Local access request |
| loc_we | output | 1 | Local write enable |
| loc_space | output | 1 | 0 = register file, 1 = shared buffer |
| loc_addr | output | MEM_AW | Local address |
| loc_wdata | output | 8 | Local write data |
| loc_rdata | input | 8 | Local read data |
| loc_ack | input | 1 | Local acknowledge |

## Verification
The bench toggles the qualifier throughout the data phase of reads and writes, including four back-to-back sub-cycles. A design that let it end the cycle would drop the drivers early, and the bench would read 8'hFF. It pulses the command strobe high for a single clock in mid-cycle. A controller that ends on one sample would lose output enable there. It also starves the local acknowledge, both with a finite timeout and with the timeout disabled, to show the stretch is released only when it should be. Miss cases cover a window boundary on each side and a memory access latched with the qualifier low. There a wrong decode would show as a selected card or a driven bus.

// File: rtl/chan8_pkg.sv
package chan8_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_WCAP,
        ST_ACCESS,
        ST_HOLD
    } cyc_state_t;

    typedef enum logic {
        SPC_IO  = 1'b0,
        SPC_MEM = 1'b1
    } space_t;

    typedef struct packed {
        logic   is_wr;
        space_t space;
    } cyc_attr_t;

    localparam logic [7:0] FLOAT_BYTE = 8'hFF;

    // Compare bits [top-1:low] of two addresses.
    function automatic logic field_match(logic [31:0] a, logic [31:0] base,
                                         int unsigned top, int unsigned low);
        logic m;
        m = 1'b1;
        for (int i = 0; i < 32; i++) begin
            if (i >= low && i < top && a[i] != base[i]) m = 1'b0;
        end
        return m;
    endfunction

endpackage

// File: rtl/chan8_sync.sv
module chan8_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            logic s1, s2;
            always_ff @(posedge clk) begin
                if (rst) begin
                    s1 <= 1'b1;
                    s2 <= 1'b1;
                end else begin
                    s1 <= d[g];
                    s2 <= s1;
                end
            end
            assign q[g] = s2;
        end
    endgenerate
endmodule

// File: rtl/chan8_decode.sv
module chan8_decode
    import chan8_pkg::*;
#(
    parameter int              ADDR_W   = 24,
    parameter logic [31:0]     IO_BASE  = 32'h0000_0300,
    parameter int              IO_AW    = 3,
    parameter logic [31:0]     MEM_BASE = 32'h000D_4000,
    parameter int              MEM_AW   = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mio,
    input  logic              qual,
    output logic              hit,
    output space_t            space,
    output logic [MEM_AW-1:0] laddr
);
    localparam int PAD_W = MEM_AW - IO_AW;

    logic io_hit, mem_hit;

    always_comb begin
        io_hit  = !mio && field_match(32'(addr), IO_BASE, ADDR_W, IO_AW);
        mem_hit = mio && qual && field_match(32'(addr), MEM_BASE, ADDR_W, MEM_AW);
        hit     = io_hit || mem_hit;
        space   = mio ? SPC_MEM : SPC_IO;
        laddr   = mio ? addr[MEM_AW-1:0] : {{PAD_W{1'b0}}, addr[IO_AW-1:0]};
    end
endmodule

// File: rtl/chan8_seq.sv
module chan8_seq
    import chan8_pkg::*;
#(
    parameter int MEM_AW = 8,
    parameter int TO_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adl_s,
    input  logic              cmd_s,
    input  logic              hit,
    input  logic              is_wr,
    input  space_t            space_in,
    input  logic [MEM_AW-1:0] laddr_in,
    input  logic [7:0]        data_in,
    input  logic [TO_W-1:0]   cfg_timeout,
    input  logic              loc_ack,
    input  logic [7:0]        loc_rdata,
    output logic              rdy,
    output logic              sel_n,
    output logic              oe,
    output logic [7:0]        dout,
    output logic              loc_req,
    output logic              loc_we,
    output logic              loc_space,
    output logic [MEM_AW-1:0] loc_addr,
    output logic [7:0]        loc_wdata
);
    cyc_state_t        state;
    cyc_attr_t         attr;
    logic              adl_q;
    logic              hi_seen;
    logic [TO_W-1:0]   to_cnt;
    logic [MEM_AW-1:0] laddr_q;
    logic [7:0]        wdata_q;
    logic [7:0]        rdata_q;
    logic              adl_fall;
    logic              to_hit;

    assign adl_fall = adl_q && !adl_s;
    assign to_hit   = (cfg_timeout != '0) && (to_cnt == cfg_timeout - TO_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            attr    <= '{is_wr: 1'b0, space: SPC_IO};
            adl_q   <= 1'b1;
            hi_seen <= 1'b0;
            to_cnt  <= '0;
            laddr_q <= '0;
            wdata_q <= '0;
            rdata_q <= FLOAT_BYTE;
        end else begin
            adl_q <= adl_s;
            unique case (state)
                ST_IDLE: begin
                    if (adl_fall && hit) begin
                        attr    <= '{is_wr: is_wr, space: space_in};
                        laddr_q <= laddr_in;
                        rdata_q <= FLOAT_BYTE;
                        state   <= ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (!cmd_s) begin
                        to_cnt <= '0;
                        state  <= attr.is_wr ? ST_WCAP : ST_ACCESS;
                    end
                end
                ST_WCAP: begin
                    wdata_q <= data_in;
                    state   <= ST_ACCESS;
                end
                ST_ACCESS: begin
                    if (loc_ack) begin
                        if (!attr.is_wr) rdata_q <= loc_rdata;
                        hi_seen <= 1'b0;
                        state   <= ST_HOLD;
                    end else if (to_hit) begin
                        rdata_q <= FLOAT_BYTE;
                        hi_seen <= 1'b0;
                        state   <= ST_HOLD;
                    end else begin
                        to_cnt <= to_cnt + TO_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (cmd_s) begin
                        if (hi_seen) state <= ST_IDLE;
                        else         hi_seen <= 1'b1;
                    end else begin
                        hi_seen <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sel_n     = (state == ST_IDLE);
        rdy       = !(state inside {ST_ARMED, ST_WCAP, ST_ACCESS});
        oe        = !attr.is_wr && (state inside {ST_ACCESS, ST_HOLD});
        dout      = rdata_q;
        loc_req   = (state == ST_ACCESS);
        loc_we    = attr.is_wr;
        loc_space = attr.space;
        loc_addr  = laddr_q;
        loc_wdata = wdata_q;
    end
endmodule

// File: rtl/chan8_slave.sv
module chan8_slave
    import chan8_pkg::*;
#(
    parameter int          ADDR_W   = 24,
    parameter logic [31:0] IO_BASE  = 32'h0000_0300,
    parameter int          IO_AW    = 3,
    parameter logic [31:0] MEM_BASE = 32'h000D_4000,
    parameter int          MEM_AW   = 8,
    parameter int          TO_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TO_W-1:0]   cfg_timeout,
    input  logic              bus_adl_n,
    input  logic              bus_cmd_n,
    input  logic              bus_mio,
    input  logic              bus_wr,
    input  logic              bus_qual,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_din,
    output logic [7:0]        bus_dout,
    output logic              bus_data_oe,
    output logic              bus_rdy,
    output logic              bus_sel_n,
    output logic              loc_req,
    output logic              loc_we,
    output logic              loc_space,
    output logic [MEM_AW-1:0] loc_addr,
    output logic [7:0]        loc_wdata,
    input  logic [7:0]        loc_rdata,
    input  logic              loc_ack
);
    logic [1:0]        strobe_s;
    logic              dec_hit;
    space_t            dec_space;
    logic [MEM_AW-1:0] dec_laddr;

    chan8_sync #(.W(2)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({bus_cmd_n, bus_adl_n}),
        .q   (strobe_s)
    );

    chan8_decode #(
        .ADDR_W   (ADDR_W),
        .IO_BASE  (IO_BASE),
        .IO_AW    (IO_AW),
        .MEM_BASE (MEM_BASE),
        .MEM_AW   (MEM_AW)
    ) dec_i (
        .addr  (bus_addr),
        .mio   (bus_mio),
        .qual  (bus_qual),
        .hit   (dec_hit),
        .space (dec_space),
        .laddr (dec_laddr)
    );

    chan8_seq #(
        .MEM_AW (MEM_AW),
        .TO_W   (TO_W)
    ) seq_i (
        .clk         (clk),
        .rst         (rst),
        .adl_s       (strobe_s[0]),
        .cmd_s       (strobe_s[1]),
        .hit         (dec_hit),
        .is_wr       (bus_wr),
        .space_in    (dec_space),
        .laddr_in    (dec_laddr),
        .data_in     (bus_din),
        .cfg_timeout (cfg_timeout),
        .loc_ack     (loc_ack),
        .loc_rdata   (loc_rdata),
        .rdy         (bus_rdy),
        .sel_n       (bus_sel_n),
        .oe          (bus_data_oe),
        .dout        (bus_dout),
        .loc_req     (loc_req),
        .loc_we      (loc_we),
        .loc_space   (loc_space),
        .loc_addr    (loc_addr),
        .loc_wdata   (loc_wdata)
    );
endmodule

// File: rtl/chan8_slave_chk.sv
module chan8_slave_chk #(
    parameter int MEM_AW = 8,
    parameter int TO_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [TO_W-1:0]   cfg_timeout,
    input logic              bus_adl_n,
    input logic              bus_cmd_n,
    input logic              bus_data_oe,
    input logic              bus_rdy,
    input logic              bus_sel_n,
    input logic              loc_req,
    input logic              loc_we,
    input logic [MEM_AW-1:0] loc_addr,
    input logic [7:0]        loc_wdata
);
    logic [TO_W:0] req_run;

    always_ff @(posedge clk) begin
        if (rst)          req_run <= '0;
        else if (loc_req) req_run <= req_run + 1'b1;
        else              req_run <= '0;
    end

    // Selection only follows a latched address strobe.
    assert_sel_from_adl_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_sel_n) |-> !$past(bus_adl_n, 3));

    // The stretch is only driven by a selected card.
    assert_stretch_selected_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_rdy |-> !bus_sel_n);

    // Drivers are only on while selected.
    assert_oe_selected_R4: assert property (@(posedge clk) disable iff (rst)
        bus_data_oe |-> !bus_sel_n);

    // Release needs two high samples of the command strobe.
    assert_oe_release_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_data_oe) |-> ($past(bus_cmd_n, 3) && $past(bus_cmd_n, 4)));

    assert_sel_release_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_sel_n) |-> ($past(bus_cmd_n, 3) && $past(bus_cmd_n, 4)));

    // Local request fields hold while the request is pending.
    assert_req_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (loc_req && $past(loc_req)) |-> ($stable(loc_wdata) && $stable(loc_addr) && $stable(loc_we)));

    // Request never outlives the timeout.
    assert_timeout_R8: assert property (@(posedge clk) disable iff (rst)
        (loc_req && cfg_timeout != '0) |-> (req_run < {1'b0, cfg_timeout}));
endmodule

bind chan8_slave chan8_slave_chk #(.MEM_AW(MEM_AW), .TO_W(TO_W)) chk_i (.*);

// File: tb/chan8_slave_tb_top.sv
module chan8_slave_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_timeout = 8'd20;
    logic        bus_adl_n = 1'b1;
    logic        bus_cmd_n = 1'b1;
    logic        bus_mio = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_qual = 1'b1;
    logic [23:0] bus_addr = '0;
    logic [7:0]  bus_din = '0;
    logic [7:0]  bus_dout;
    logic        bus_data_oe, bus_rdy, bus_sel_n;
    logic        loc_req, loc_we, loc_space;
    logic [7:0]  loc_addr, loc_wdata, loc_rdata;
    logic        ack_r = 1'b0;
    logic        noack = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    chan8_slave dut_i (
        .clk(clk), .rst(rst), .cfg_timeout(cfg_timeout),
        .bus_adl_n(bus_adl_n), .bus_cmd_n(bus_cmd_n), .bus_mio(bus_mio),
        .bus_wr(bus_wr), .bus_qual(bus_qual), .bus_addr(bus_addr),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_data_oe(bus_data_oe),
        .bus_rdy(bus_rdy), .bus_sel_n(bus_sel_n), .loc_req(loc_req),
        .loc_we(loc_we), .loc_space(loc_space), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .loc_ack(ack_r)
    );

    // Local side model: register file and shared buffer, one-clock ack.
    logic [7:0] buf_mem [256];
    logic [7:0] regs [8];

    assign loc_rdata = loc_space ? buf_mem[loc_addr] : regs[loc_addr[2:0]];

    always @(posedge clk) begin
        ack_r <= loc_req && !ack_r && !noack;
        if (loc_req && !ack_r && !noack && loc_we) begin
            if (loc_space) buf_mem[loc_addr]   <= loc_wdata;
            else           regs[loc_addr[2:0]] <= loc_wdata;
        end
    end

    typedef struct packed {
        logic        mem;
        logic        wr;
        logic        qual;
        logic        tog;
        logic [23:0] addr;
        logic [7:0]  wdata;
        logic        hit;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b1, 1'b0, 24'h000300, 8'h5A, 1'b1, 8'hFF},
        '{1'b0, 1'b1, 1'b1, 1'b1, 24'h000307, 8'hC3, 1'b1, 8'hFF},
        '{1'b0, 1'b0, 1'b1, 1'b0, 24'h000300, 8'h00, 1'b1, 8'h5A},
        '{1'b0, 1'b0, 1'b1, 1'b1, 24'h000307, 8'h00, 1'b1, 8'hC3},
        '{1'b1, 1'b1, 1'b1, 1'b1, 24'h0D4010, 8'h3C, 1'b1, 8'hFF},
        '{1'b1, 1'b1, 1'b1, 1'b1, 24'h0D4011, 8'h11, 1'b1, 8'hFF},
        '{1'b1, 1'b1, 1'b1, 1'b0, 24'h0D4012, 8'h22, 1'b1, 8'hFF},
        '{1'b1, 1'b1, 1'b1, 1'b1, 24'h0D4013, 8'h33, 1'b1, 8'hFF},
        '{1'b1, 1'b0, 1'b1, 1'b1, 24'h0D4010, 8'h00, 1'b1, 8'h3C},
        '{1'b0, 1'b0, 1'b1, 1'b0, 24'h000308, 8'h00, 1'b0, 8'hFF},
        '{1'b0, 1'b0, 1'b1, 1'b0, 24'h0002FF, 8'h00, 1'b0, 8'hFF},
        '{1'b1, 1'b0, 1'b1, 1'b0, 24'h0D4100, 8'h00, 1'b0, 8'hFF},
        '{1'b1, 1'b0, 1'b0, 1'b0, 24'h0D4010, 8'h00, 1'b0, 8'hFF}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle. Inputs change on falling edges only.
    task automatic bus_cycle(input logic mem, input logic wr, input logic qual,
                             input logic tog, input logic glitch,
                             input logic [23:0] addr, input logic [7:0] wd,
                             output logic [7:0] got, output logic sel_seen,
                             output int stretch);
        @(negedge clk);
        bus_addr = addr; bus_mio = mem; bus_wr = wr; bus_qual = qual;
        bus_din = wd; bus_adl_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_adl_n = 1'b1;
        bus_cmd_n = 1'b0;
        sel_seen = 1'b0;
        stretch = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!bus_sel_n) sel_seen = 1'b1;
            if (tog) bus_qual = ~bus_qual;
            if (!bus_rdy) stretch++;
            else if (i >= 4) break;
        end
        if (glitch) begin
            bus_cmd_n = 1'b1;
            @(negedge clk);
            bus_cmd_n = 1'b0;
            repeat (5) @(negedge clk);
            chk("R5 oe held after one-clock cmd pulse", 32'(bus_data_oe), 32'(1));
            chk("R5 sel held after one-clock cmd pulse", 32'(bus_sel_n), 32'(0));
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (tog) begin
                bus_qual = ~bus_qual;
                if (!wr && sel_seen)
                    chk("R6 oe unaffected by qualifier", 32'(bus_data_oe), 32'(1));
            end
        end
        got = bus_data_oe ? bus_dout : 8'hFF;
        bus_cmd_n = 1'b1;
        repeat (6) @(negedge clk);
        bus_qual = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] got;
        logic       sel_seen;
        int         stretch;
        for (int i = 0; i < 256; i++) buf_mem[i] = 8'h00;
        for (int i = 0; i < 8; i++) regs[i] = 8'h00;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 rdy", 32'(bus_rdy), 32'(1));
        chk("R1 sel_n", 32'(bus_sel_n), 32'(1));
        chk("R1 oe", 32'(bus_data_oe), 32'(0));
        chk("R1 loc_req", 32'(loc_req), 32'(0));
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // Vector table: R2, R3, R4, R6, R7
        for (int v = 0; v < NV; v++) begin
            bus_cycle(VECS[v].mem, VECS[v].wr, VECS[v].qual, VECS[v].tog, 1'b0,
                      VECS[v].addr, VECS[v].wdata, got, sel_seen, stretch);
            chk($sformatf("R2/R3 select vec %0d", v), 32'(sel_seen), 32'(VECS[v].hit));
            if (!VECS[v].wr)
                chk($sformatf("R4 read data vec %0d", v), 32'(got), 32'(VECS[v].exp));
            if (VECS[v].hit)
                chk($sformatf("R4/R7 stretch seen vec %0d", v), 32'(stretch > 0), 32'(1));
            chk($sformatf("R5 idle after vec %0d", v),
                32'({bus_sel_n, bus_data_oe, bus_rdy, loc_req}), 32'(4'b1010));
        end

        // R10 local mapping of writes
        chk("R10 io reg 7", 32'(regs[7]), 32'(8'hC3));
        chk("R10 buffer 0x10", 32'(buf_mem[8'h10]), 32'(8'h3C));
        chk("R10 buffer 0x13", 32'(buf_mem[8'h13]), 32'(8'h33));

        // R9 four consecutive sub-cycles with qualifier toggling
        for (int k = 0; k < 4; k++) begin
            bus_cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 24'h0D4010 + 24'(k), 8'h00,
                      got, sel_seen, stretch);
            chk($sformatf("R9 sub-cycle %0d", k), 32'(got),
                32'((k == 0) ? 8'h3C : (k == 1) ? 8'h11 : (k == 2) ? 8'h22 : 8'h33));
        end

        // Local side writes the buffer directly; host reads it (R10)
        buf_mem[8'h40] = 8'hA7;
        bus_cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 24'h0D4040, 8'h00, got, sel_seen, stretch);
        chk("R10 host sees local buffer write", 32'(got), 32'(8'hA7));

        // R5 single-clock high pulse on cmd does not end the cycle
        bus_cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 24'h000307, 8'h00, got, sel_seen, stretch);
        chk("R5 data after pulse", 32'(got), 32'(8'hC3));

        // R8 timeout releases stretch and reads float byte
        noack = 1'b1;
        cfg_timeout = 8'd5;
        bus_cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 24'h000300, 8'h00, got, sel_seen, stretch);
        chk("R8 timeout read value", 32'(got), 32'(8'hFF));
        chk("R8 timeout stretch bounded", 32'(stretch <= 10), 32'(1));
        chk("R8 request dropped", 32'(loc_req), 32'(0));

        // R8 zero disables the timeout
        cfg_timeout = 8'd0;
        @(negedge clk);
        bus_addr = 24'h000300; bus_mio = 1'b0; bus_wr = 1'b0; bus_adl_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_adl_n = 1'b1;
        bus_cmd_n = 1'b0;
        repeat (40) @(negedge clk);
        chk("R8 stretch held with timeout off", 32'(bus_rdy), 32'(0));
        noack = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 ready after late ack", 32'(bus_rdy), 32'(1));
        chk("R4 late ack data", 32'(bus_data_oe ? bus_dout : 8'hFF), 32'(8'h5A));
        bus_cmd_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R5 released after cmd high", 32'({bus_sel_n, bus_data_oe}), 32'(2'b10));
        cfg_timeout = 8'd20;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule